// File: doc/BRIEF.md
# PHY Deep Power-Down Sequencer

This block decides when a 10/100 Ethernet PHY may drop into its deepest power-saving state, and which internal sections it actually switches off there. It watches two conditions: whether the link partner is producing any line activity, and whether the MAC is asserting transmit enable. Only when the line is silent and the MAC is quiet, without a break, for a long qualification window does the block enter power-down. The window counts cycles of the 25 MHz reference clock. By default it lasts 32 s (800,000,000 cycles). A parameter shortens it so that simulation stays practical.

In power-down, the block raises one power-down enable per internal section. Each enable is gated by its own bit of a five-bit configuration mask. The sections are clock and data recovery, the transmit DAC, the receiver with its equalizer, the transmit PLL, and one auxiliary section. When the transmit DAC is switched off, a separate output tells the transmit output stage to go high impedance.

Any link activity or any assertion of transmit enable wakes the block in the same cycle. It drops every enable at once and restarts the qualification window from zero.

Top module: `pdn_sequencer`

## Requirements
- R1: While `rst_n` is low, `dpd_active`, every bit of `pd_en` and `tx_hiz` are 0, and the idle count is cleared.
- R2: A cycle is idle when `link_up` and `tx_en` are both 0. `dpd_active` is 1 in a cycle exactly when that cycle is idle and the TIMEOUT_CYCLES clock edges just before it all sampled idle cycles.
- R3: A cycle with `link_up` high during qualification discards all idle cycles counted so far. Entry then needs a fresh run of TIMEOUT_CYCLES idle cycles.
- R4: A cycle with `tx_en` high during qualification discards all idle cycles counted so far, in the same way as R3.
- R5: In the same cycle that `link_up` or `tx_en` goes high, `dpd_active` and every bit of `pd_en` are 0. No clock edge is needed for this.
- R6: `pd_en[i]` equals `dpd_active & pd_mask[i]`. The bit positions are fixed: bit 0 is clock/data recovery, bit 1 is the transmit DAC, bit 2 is receiver and equalizer, bit 3 is the transmit PLL, and bit 4 is the auxiliary section. These correspond to configuration register bits 4 to 8.
- R7: `tx_hiz` is 1 exactly when the transmit DAC power-down enable (`pd_en[1]`) is 1.
- R8: `pd_mask` has no effect on the qualification timer. Changing it while the block is not in power-down does not alter when `dpd_active` rises.
- R9: Once entered, power-down persists for as long as idle continues, however long that is. The count saturates and does not wrap.
- R10: After a wake, re-entry again requires a full TIMEOUT_CYCLES run of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Line activity from the link partner detected |
| tx_en | input | 1 | MAC transmit enable |
| pd_mask | input | 5 | Per-section power-down permission (config bits 4..8) |
| dpd_active | output | 1 | Block is in deep power-down |
| pd_en | output | 5 | Per-section power-down enables |
| tx_hiz | output | 1 | Transmit output stage to high impedance |

## Verification
The bound checker keeps its own count of consecutive idle cycles. On every cycle it confirms four things: power-down is never active before a full idle run, it is never missing once a full run holds, any wake input clears all enables at once, and no enable or `tx_hiz` is raised outside power-down. Some behaviour can only be shown by the bench's scenarios. These are the exact boundary at TIMEOUT_CYCLES−1 versus TIMEOUT_CYCLES idle cycles, restarts triggered separately by link activity and by transmit enable, the per-section bit positions under changing masks, long dwell in power-down, and re-entry after a wake.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

   // Section positions inside the power-down enable vector.
   typedef enum int unsigned {
      SECT_CDR   = 0,
      SECT_TXDAC = 1,
      SECT_RXEQ  = 2,
      SECT_TXPLL = 3,
      SECT_AUX   = 4
   } pdn_sect_e;

   localparam int unsigned PDN_NUM_SECT = 5;

   // 32 s of the 25 MHz reference.
   localparam longint unsigned PDN_REF_HZ       = 25_000_000;
   localparam longint unsigned PDN_DWELL_SEC    = 32;
   localparam int unsigned     PDN_TIMEOUT_DFLT = int'(PDN_REF_HZ * PDN_DWELL_SEC);

endpackage

// File: rtl/pdn_idle_timer.sv
module pdn_idle_timer #(
   parameter int unsigned TIMEOUT_CYCLES = pdn_pkg::PDN_TIMEOUT_DFLT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_up,
   input  logic tx_en,
   output logic sleep
);

   localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   if (TIMEOUT_CYCLES < 2) begin : g_bad_timeout
      $error("pdn_idle_timer: TIMEOUT_CYCLES must be at least 2");
   end

   logic             idle;
   logic             full;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_d;

   assign idle = ~link_up & ~tx_en;
   assign full = (run_q == LIMIT);

   // Count idle edges, saturate at the limit, clear on any activity.
   always_comb begin
      if (!idle)
         run_d = '0;
      else if (full)
         run_d = run_q;
      else
         run_d = run_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else
         run_q <= run_d;
   end

   // Exit is combinational on the wake inputs; no edge needed.
   assign sleep = full & idle;

endmodule

// File: rtl/pdn_section_gate.sv
module pdn_section_gate #(
   parameter int unsigned NUM_SECT = pdn_pkg::PDN_NUM_SECT,
   parameter int unsigned DAC_IDX  = pdn_pkg::SECT_TXDAC
) (
   input  logic                sleep,
   input  logic [NUM_SECT-1:0] mask,
   output logic [NUM_SECT-1:0] pd_en,
   output logic                tx_hiz
);

   if (DAC_IDX >= NUM_SECT) begin : g_bad_dac
      $error("pdn_section_gate: DAC_IDX outside the section vector");
   end

   for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
      assign pd_en[i] = sleep & mask[i];
   end

   assign tx_hiz = pd_en[DAC_IDX];

endmodule

// File: rtl/pdn_sequencer.sv
module pdn_sequencer #(
   parameter int unsigned TIMEOUT_CYCLES = pdn_pkg::PDN_TIMEOUT_DFLT,
   parameter int unsigned NUM_SECT       = pdn_pkg::PDN_NUM_SECT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                link_up,
   input  logic                tx_en,
   input  logic [NUM_SECT-1:0] pd_mask,
   output logic                dpd_active,
   output logic [NUM_SECT-1:0] pd_en,
   output logic                tx_hiz
);

   if (NUM_SECT != pdn_pkg::PDN_NUM_SECT) begin : g_bad_sect
      $error("pdn_sequencer: section count must match the package");
   end

   logic sleep;

   pdn_idle_timer #(
      .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .link_up(link_up),
      .tx_en  (tx_en),
      .sleep  (sleep)
   );

   pdn_section_gate #(
      .NUM_SECT(NUM_SECT),
      .DAC_IDX (pdn_pkg::SECT_TXDAC)
   ) u_gate (
      .sleep (sleep),
      .mask  (pd_mask),
      .pd_en (pd_en),
      .tx_hiz(tx_hiz)
   );

   assign dpd_active = sleep;

endmodule

// File: rtl/pdn_sequencer_chk.sv
module pdn_sequencer_chk #(
   parameter int unsigned TIMEOUT_CYCLES = 2,
   parameter int unsigned NUM_SECT       = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                link_up,
   input logic                tx_en,
   input logic [NUM_SECT-1:0] pd_mask,
   input logic                dpd_active,
   input logic [NUM_SECT-1:0] pd_en,
   input logic                tx_hiz
);

   // Independent run length of idle edges, saturating at the timeout.
   int unsigned run;
   logic        quiet;
   assign quiet = !link_up && !tx_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run <= 0;
      else if (!quiet)
         run <= 0;
      else if (run < TIMEOUT_CYCLES)
         run <= run + 1;
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!dpd_active && pd_en == '0 && !tx_hiz));

   p_no_early_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dpd_active |-> (quiet && run == TIMEOUT_CYCLES));

   p_stay_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && run == TIMEOUT_CYCLES) |-> dpd_active);

   p_wake_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up || tx_en) |-> (!dpd_active && pd_en == '0));

   p_enable_needs_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_en != '0) |-> (dpd_active && (pd_en & ~pd_mask) == '0));

   p_hiz_follows_dac_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_hiz |-> (dpd_active && pd_mask[1]));

endmodule

bind pdn_sequencer pdn_sequencer_chk #(
   .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
   .NUM_SECT      (NUM_SECT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .link_up   (link_up),
   .tx_en     (tx_en),
   .pd_mask   (pd_mask),
   .dpd_active(dpd_active),
   .pd_en     (pd_en),
   .tx_hiz    (tx_hiz)
);

// File: tb/pdn_sequencer_bench.sv
module pdn_sequencer_bench;

   localparam int unsigned T = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       link_up = 1'b0;
   logic       tx_en = 1'b0;
   logic [4:0] pd_mask = 5'b0;
   logic       dpd_active;
   logic [4:0] pd_en;
   logic       tx_hiz;

   int unsigned vectors = 0;
   int unsigned miscompares = 0;
   int unsigned mcnt = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   pdn_sequencer #(.TIMEOUT_CYCLES(T)) u_pdn_sequencer (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_up   (link_up),
      .tx_en     (tx_en),
      .pd_mask   (pd_mask),
      .dpd_active(dpd_active),
      .pd_en     (pd_en),
      .tx_hiz    (tx_hiz)
   );

   function automatic bit exp_active(int unsigned cnt, bit lk, bit tx);
      return (!lk && !tx && cnt == T);
   endfunction

   function automatic logic [4:0] exp_pd(bit act, logic [4:0] m);
      return act ? m : 5'b0;
   endfunction

   task automatic check_outputs(string tag);
      bit         ea;
      logic [4:0] ep;
      ea = exp_active(mcnt, link_up, tx_en);
      ep = exp_pd(ea, pd_mask);
      vectors++;
      if (dpd_active !== ea) begin
         miscompares++;
         $display("FAIL %s/R2 dpd_active act %b exp %b", tag, dpd_active, ea);
      end
      vectors++;
      if (pd_en !== ep) begin
         miscompares++;
         $display("FAIL %s/R6 pd_en act %b exp %b", tag, pd_en, ep);
      end
      vectors++;
      if (tx_hiz !== ep[1]) begin
         miscompares++;
         $display("FAIL %s/R7 tx_hiz act %b exp %b", tag, tx_hiz, ep[1]);
      end
   endtask

   // Drive one cycle of inputs, check combinational outputs, then advance the model.
   task automatic step(bit lk, bit tx, logic [4:0] m, string tag);
      @(negedge clk);
      link_up = lk;
      tx_en   = tx;
      pd_mask = m;
      #1;
      check_outputs(tag);
      @(posedge clk);
      if (lk || tx)
         mcnt = 0;
      else if (mcnt < T)
         mcnt = mcnt + 1;
   endtask

   task automatic idle_run(int unsigned n, logic [4:0] m, string tag);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, m, tag);
   endtask

   initial begin
      void'($urandom(32'h5EED_1894));
      // R1: reset state, including while inputs are idle.
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         pd_mask = 5'h1F;
         #1;
         vectors++;
         if (dpd_active !== 1'b0 || pd_en !== 5'b0 || tx_hiz !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset outputs act %b/%b/%b exp 0/00000/0",
                     dpd_active, pd_en, tx_hiz);
         end
      end
      @(negedge clk);
      rst_n = 1'b1;
      mcnt = 0;

      // R3: link activity one cycle before the limit restarts the run.
      idle_run(T - 1, 5'h1F, "R3");
      step(1'b1, 1'b0, 5'h1F, "R3");
      idle_run(T - 1, 5'h1F, "R3");
      // R2: the T-th idle cycle completes the run; active from the next one.
      idle_run(3, 5'h1F, "R2");
      // R9: long dwell with changing masks covers every section bit (R6).
      for (int i = 0; i < 2 * T; i++)
         step(1'b0, 1'b0, 5'(1 << (i % 5)), "R9");
      // R5: transmit enable wakes at once.
      step(1'b0, 1'b1, 5'h1F, "R5");
      // R4: transmit enable one cycle before the limit restarts the run.
      idle_run(T - 1, 5'h1F, "R4");
      step(1'b0, 1'b1, 5'h1F, "R4");
      // R10 with R8: full run again, mask toggled while counting.
      for (int i = 0; i < T + 4; i++)
         step(1'b0, 1'b0, 5'($urandom_range(0, 31)), "R10");
      // R5: link activity wakes at once.
      step(1'b1, 1'b0, 5'h1F, "R5");
      // R8: zero mask during the count, full mask afterwards; entry timing unchanged.
      idle_run(T - 2, 5'h00, "R8");
      idle_run(5, 5'h1F, "R8");

      // Constrained random: mostly idle, sparse activity bursts.
      for (int i = 0; i < 4000; i++) begin
         bit lk;
         bit tx;
         lk = ($urandom_range(0, 59) == 0);
         tx = ($urandom_range(0, 59) == 0);
         step(lk, tx, 5'($urandom_range(0, 31)), "RND");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(10 * 100_000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired act running exp finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule